// File: doc/BRIEF.md
# Width-Dependent Compressed Instruction Expander

This block turns one 16-bit compressed instruction into the 32-bit base instruction that performs the same operation. It is purely combinational, so a decode stage can place it directly in front of the full-width decoder. A one-bit width select tells it whether the core is running as a 32-bit or a 64-bit machine. That select matters because one compressed slot decodes differently at the two widths: at 32 bits it is a jump-and-link, and at 64 bits it is an add-immediate-word.

The block handles a specific set of forms. These are the doubleword loads and stores (both the register-based form and the stack-pointer form), the word add and word subtract, and the width-dependent slot in quadrant 01. Any other halfword is reported as illegal and the output word is forced to zero. The doubleword and word-arithmetic forms are accepted only in 64-bit mode.

Top module: `cinst_expander`

## Requirements
- R1: With xlen64_in=0, a halfword with bits[1:0]=01 and bits[15:13]=001 expands to a jump-and-link with rd=x1 (opcode 1101111). The signed 12-bit offset has bit 0 equal to zero. Halfword bits 12,11,10:9,8,7,6,5:3,2 carry offset bits 11,4,9:8,10,6,7,3:1,5 respectively.
- R2: With xlen64_in=1, the same slot expands to an add-immediate-word when bits[11:7] are not zero. The result has opcode 0011011 and funct3 000, with rd=rs1=bits[11:7]. The immediate is {bit12, bits[6:2]}, sign-extended to 12 bits.
- R3: With xlen64_in=1, that slot with bits[11:7]=0 is illegal.
- R4: Quadrant 00 with funct3 011 expands to a doubleword load (opcode 0000011, funct3 011), and funct3 111 expands to a doubleword store (opcode 0100011, funct3 011). The base register is 01 followed by bits[9:7]. The loaded or stored register is 01 followed by bits[4:2]. The offset is zero-extended: bits[12:10] give offset[5:3], bits[6:5] give offset[7:6], and offset[2:0] is zero.
- R5: Quadrant 10 with funct3 011 expands to a doubleword load from base x2 into rd=bits[11:7]. Bit 12 gives offset[5], bits[6:5] give offset[4:3], bits[4:2] give offset[8:6], and the rest are zero. The form is illegal when rd is zero.
- R6: Quadrant 10 with funct3 111 expands to a doubleword store to base x2 of rs2=bits[6:2]. Bits[12:10] give offset[5:3], bits[9:7] give offset[8:6], and the rest are zero.
- R7: Quadrant 01 with bits[15:10]=100111 and bit 6 equal to 0 is a word operation. Bit 5 equal to 0 selects a subtract (funct7 0100000) and bit 5 equal to 1 selects an add (funct7 0000000). Both use opcode 0111011 and funct3 000. The rd and rs1 register is 01 followed by bits[9:7], and rs2 is 01 followed by bits[4:2].
- R8: With xlen64_in=0, every form of R4 to R7 is illegal.
- R9: Any halfword outside R1 to R7, including the all-zero halfword and any halfword with bits[1:0]=11, is illegal. Whenever illegal_out is 1, instr_out is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hw_in | input | 16 | Compressed instruction halfword |
| xlen64_in | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| instr_out | output | 32 | Expanded base instruction, zero when illegal |
| illegal_out | output | 1 | High when the halfword is not an accepted form |

## Verification
The block holds no state, so any wrong decode shows up on instr_out or illegal_out as soon as the inputs settle, in the same cycle. A wrong quadrant select or a wrong width gate shows as a wrong illegal flag or a wrong opcode field. A misplaced offset bit shows only for the halfwords that set that bit. For this reason the bench sweeps every halfword in both width modes and compares every one against an arithmetic reference.

// File: rtl/cinst_pkg.sv
// Shared constants, result type and base-format encoders for the
// compressed expander. Assumes 16-bit input halfwords and 32-bit output words.
package cinst_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 32;
    localparam int REG_W  = 5;

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef struct packed {
        logic              ok;
        logic [WORD_W-1:0] word;
    } exp_res_t;

    localparam exp_res_t RES_NONE = '{ok: 1'b0, word: '0};

    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_IMM32  = 7'b0011011;
    localparam logic [6:0] OPC_REG32  = 7'b0111011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;

    localparam logic [2:0] F3_DWORD   = 3'b011;
    localparam logic [2:0] F3_ADDSUB  = 3'b000;

    localparam logic [6:0] F7_ADD     = 7'b0000000;
    localparam logic [6:0] F7_SUB     = 7'b0100000;

    localparam reg_idx_t REG_ZERO = 5'd0;
    localparam reg_idx_t REG_LINK = 5'd1;
    localparam reg_idx_t REG_SP   = 5'd2;

    // Map a 3-bit short register field onto x8..x15.
    function automatic reg_idx_t short_reg(input logic [2:0] f);
        return {2'b01, f};
    endfunction

    // Immediate-format word.
    function automatic logic [WORD_W-1:0] fmt_i(input logic [11:0] imm,
                                                input reg_idx_t rs1,
                                                input logic [2:0] f3,
                                                input reg_idx_t rd,
                                                input logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction

    // Store-format word.
    function automatic logic [WORD_W-1:0] fmt_s(input logic [11:0] imm,
                                                input reg_idx_t rs2,
                                                input reg_idx_t rs1,
                                                input logic [2:0] f3,
                                                input logic [6:0] op);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
    endfunction

    // Register-format word.
    function automatic logic [WORD_W-1:0] fmt_r(input logic [6:0] f7,
                                                input reg_idx_t rs2,
                                                input reg_idx_t rs1,
                                                input logic [2:0] f3,
                                                input reg_idx_t rd,
                                                input logic [6:0] op);
        return {f7, rs2, rs1, f3, rd, op};
    endfunction

    // Jump-format word from a 21-bit byte offset.
    function automatic logic [WORD_W-1:0] fmt_j(input logic [20:0] off,
                                                input reg_idx_t rd,
                                                input logic [6:0] op);
        return {off[20], off[10:1], off[11], off[19:12], rd, op};
    endfunction

endpackage

// File: rtl/cinst_q0.sv
// Quadrant 00 expander: register-based doubleword load and store.
// Assumes the caller has already selected quadrant 00; bits[1:0] are not passed.
module cinst_q0
    import cinst_pkg::*;
(
    input  logic [HALF_W-1:2] hw,
    input  logic              is64,
    output exp_res_t          res
);
    logic [2:0]  f3;
    logic [11:0] off;

    assign f3  = hw[15:13];
    assign off = {4'b0000, hw[6:5], hw[12:10], 3'b000};

    // Pick the doubleword load or store when the width allows it.
    always_comb begin
        res = RES_NONE;
        if (is64) begin
            if (f3 == 3'b011) begin
                res.ok   = 1'b1;
                res.word = fmt_i(off, short_reg(hw[9:7]), F3_DWORD,
                                 short_reg(hw[4:2]), OPC_LOAD);
            end else if (f3 == 3'b111) begin
                res.ok   = 1'b1;
                res.word = fmt_s(off, short_reg(hw[4:2]), short_reg(hw[9:7]),
                                 F3_DWORD, OPC_STORE);
            end
        end
    end
endmodule

// File: rtl/cinst_q1.sv
// Quadrant 01 expander: the width-dependent jump-and-link / add-immediate-word
// slot and the word add and subtract forms.
module cinst_q1
    import cinst_pkg::*;
(
    input  logic [HALF_W-1:2] hw,
    input  logic              is64,
    output exp_res_t          res
);
    logic [2:0]  f3;
    logic [20:0] jal_off;
    logic [11:0] addiw_imm;
    reg_idx_t    full_rd;
    logic        is_wordop;

    assign f3      = hw[15:13];
    assign full_rd = hw[11:7];

    // Gather the scattered jump offset and sign-extend it to 21 bits.
    always_comb begin
        logic [11:0] o;
        o        = '0;
        o[11]    = hw[12];
        o[4]     = hw[11];
        o[9:8]   = hw[10:9];
        o[10]    = hw[8];
        o[6]     = hw[7];
        o[7]     = hw[6];
        o[3:1]   = hw[5:3];
        o[5]     = hw[2];
        jal_off  = {{9{o[11]}}, o};
    end

    assign addiw_imm = {{6{hw[12]}}, hw[12], hw[6:2]};
    assign is_wordop = (f3 == 3'b100) && (hw[12:10] == 3'b111) && !hw[6];

    // Choose among the slot variants according to the width select.
    always_comb begin
        res = RES_NONE;
        if (f3 == 3'b001) begin
            if (!is64) begin
                res.ok   = 1'b1;
                res.word = fmt_j(jal_off, REG_LINK, OPC_JAL);
            end else if (full_rd != REG_ZERO) begin
                res.ok   = 1'b1;
                res.word = fmt_i(addiw_imm, full_rd, F3_ADDSUB, full_rd, OPC_IMM32);
            end
        end else if (is_wordop && is64) begin
            res.ok   = 1'b1;
            res.word = fmt_r(hw[5] ? F7_ADD : F7_SUB, short_reg(hw[4:2]),
                             short_reg(hw[9:7]), F3_ADDSUB,
                             short_reg(hw[9:7]), OPC_REG32);
        end
    end
endmodule

// File: rtl/cinst_q2.sv
// Quadrant 10 expander: stack-pointer based doubleword load and store.
module cinst_q2
    import cinst_pkg::*;
(
    input  logic [HALF_W-1:2] hw,
    input  logic              is64,
    output exp_res_t          res
);
    logic [2:0]  f3;
    logic [11:0] ld_off;
    logic [11:0] st_off;
    reg_idx_t    full_rd;

    assign f3      = hw[15:13];
    assign full_rd = hw[11:7];
    assign ld_off  = {3'b000, hw[4:2], hw[12], hw[6:5], 3'b000};
    assign st_off  = {3'b000, hw[9:7], hw[12:10], 3'b000};

    // Pick the stack load (non-zero rd) or stack store in 64-bit mode.
    always_comb begin
        res = RES_NONE;
        if (is64) begin
            if (f3 == 3'b011 && full_rd != REG_ZERO) begin
                res.ok   = 1'b1;
                res.word = fmt_i(ld_off, REG_SP, F3_DWORD, full_rd, OPC_LOAD);
            end else if (f3 == 3'b111) begin
                res.ok   = 1'b1;
                res.word = fmt_s(st_off, hw[6:2], REG_SP, F3_DWORD, OPC_STORE);
            end
        end
    end
endmodule

// File: rtl/cinst_expander.sv
// Top of the compressed expander. Steers the halfword to the quadrant
// expander that bits[1:0] select and zeroes the output for illegal patterns.
// Purely combinational; assumes the halfword is already aligned.
module cinst_expander
    import cinst_pkg::*;
(
    input  logic [15:0] hw_in,
    input  logic        xlen64_in,
    output logic [31:0] instr_out,
    output logic        illegal_out
);
    localparam int NQ = 3;

    exp_res_t q_res [NQ];
    exp_res_t pick;

    // One expander per compressed quadrant (00, 01, 10).
    generate
        for (genvar q = 0; q < NQ; q++) begin : g_quad
            if (q == 0) begin : g_q0
                cinst_q0 u_q (.hw(hw_in[15:2]), .is64(xlen64_in), .res(q_res[q]));
            end else if (q == 1) begin : g_q1
                cinst_q1 u_q (.hw(hw_in[15:2]), .is64(xlen64_in), .res(q_res[q]));
            end else begin : g_q2
                cinst_q2 u_q (.hw(hw_in[15:2]), .is64(xlen64_in), .res(q_res[q]));
            end
        end
    endgenerate

    // Select the quadrant result; quadrant 11 is never a compressed form.
    always_comb begin
        case (hw_in[1:0])
            2'b00:   pick = q_res[0];
            2'b01:   pick = q_res[1];
            2'b10:   pick = q_res[2];
            default: pick = RES_NONE;
        endcase
    end

    assign illegal_out = !pick.ok;
    assign instr_out   = pick.ok ? pick.word : '0;
endmodule

// File: rtl/cinst_expander_chk.sv
// Port-level checker for the compressed expander, bound to the top.
module cinst_expander_chk (
    input logic [15:0] hw_in,
    input logic        xlen64_in,
    input logic [31:0] instr_out,
    input logic        illegal_out
);
    logic known;
    assign known = !$isunknown({hw_in, xlen64_in, instr_out, illegal_out});

    // Property checks on the settled combinational outputs.
    always_comb begin
        if (known) begin
            p_zero_when_illegal_r9: assert (!illegal_out || instr_out == 32'h0);
            p_quad3_illegal_r9: assert (hw_in[1:0] != 2'b11 || illegal_out);
            p_narrow_no_dword_r8: assert (xlen64_in || !(hw_in[1] == 1'b0 &&
                                    hw_in[14:13] == 2'b11) || illegal_out);
            p_jal_link_r1: assert (xlen64_in || hw_in[1:0] != 2'b01 ||
                                   hw_in[15:13] != 3'b001 ||
                                   (!illegal_out && instr_out[11:0] == 12'h0EF));
            p_addiw_zero_rd_r3: assert (!xlen64_in || hw_in[1:0] != 2'b01 ||
                                        hw_in[15:13] != 3'b001 ||
                                        hw_in[11:7] != 5'd0 || illegal_out);
            p_sp_base_r5: assert (illegal_out || hw_in[1:0] != 2'b10 ||
                                  instr_out[19:15] == 5'd2);
        end
    end
endmodule

bind cinst_expander cinst_expander_chk u_chk (
    .hw_in(hw_in),
    .xlen64_in(xlen64_in),
    .instr_out(instr_out),
    .illegal_out(illegal_out)
);

// File: tb/cinst_expander_tb.sv
// Exhaustive sweep of all halfwords in both width modes against an
// arithmetic reference, plus directed cases with hand-worked words.
module cinst_expander_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] hw_in = '0;
    logic        xlen64_in = 1'b0;
    logic [31:0] instr_out;
    logic        illegal_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cinst_expander u_dut (
        .hw_in(hw_in),
        .xlen64_in(xlen64_in),
        .instr_out(instr_out),
        .illegal_out(illegal_out)
    );

    task automatic check(input string req, input logic [31:0] exp_w,
                         input logic exp_il);
        n_cmp++;
        if (instr_out !== exp_w || illegal_out !== exp_il) begin
            n_bad++;
            $display("FAIL %s hw=%h x64=%0d: got word=%h ill=%0d, expected word=%h ill=%0d",
                     req, hw_in, xlen64_in, instr_out, illegal_out, exp_w, exp_il);
        end
    endtask

    // Reference: returns expected word and flag, and the requirement exercised.
    task automatic model(input logic [15:0] h, input logic w64,
                         output logic [31:0] w, output logic il, output string req);
        int off;
        logic [11:0] i12;
        logic [20:0] i21;
        logic [4:0] ra, rb, rfull;
        logic [2:0] f3;
        f3 = h[15:13];
        ra = 5'd8 + 5'(h[9:7]);
        rb = 5'd8 + 5'(h[4:2]);
        rfull = h[11:7];
        w = 32'h0; il = 1'b1; req = "R9";
        if (h[1:0] == 2'b00 && (f3 == 3'd3 || f3 == 3'd7)) begin
            req = w64 ? "R4" : "R8";
            if (w64) begin
                off = int'(h[12:10]) * 8 + int'(h[6:5]) * 64;
                i12 = 12'(off); il = 1'b0;
                if (f3 == 3'd3) w = {i12, ra, 3'b011, rb, 7'h03};
                else            w = {i12[11:5], rb, ra, 3'b011, i12[4:0], 7'h23};
            end
        end else if (h[1:0] == 2'b01 && f3 == 3'd1) begin
            if (!w64) begin
                req = "R1";
                off = int'(h[12]) * 2048 + int'(h[11]) * 16 + int'(h[10:9]) * 256
                    + int'(h[8]) * 1024 + int'(h[7]) * 64 + int'(h[6]) * 128
                    + int'(h[5:3]) * 2 + int'(h[2]) * 32;
                if (off >= 2048) off = off - 4096;
                i21 = 21'(off); il = 1'b0;
                w = {i21[20], i21[10:1], i21[11], i21[19:12], 5'd1, 7'h6F};
            end else if (rfull == 5'd0) begin
                req = "R3";
            end else begin
                req = "R2";
                off = int'(h[6:2]) + 32 * int'(h[12]);
                if (off >= 32) off = off - 64;
                i12 = 12'(off); il = 1'b0;
                w = {i12, rfull, 3'b000, rfull, 7'h1B};
            end
        end else if (h[1:0] == 2'b01 && h[15:10] == 6'b100111 && !h[6]) begin
            req = w64 ? "R7" : "R8";
            if (w64) begin
                il = 1'b0;
                w = {h[5] ? 7'h00 : 7'h20, rb, ra, 3'b000, ra, 7'h3B};
            end
        end else if (h[1:0] == 2'b10 && f3 == 3'd3) begin
            req = w64 ? "R5" : "R8";
            if (w64 && rfull != 5'd0) begin
                off = int'(h[12]) * 32 + int'(h[6:5]) * 8 + int'(h[4:2]) * 64;
                i12 = 12'(off); il = 1'b0;
                w = {i12, 5'd2, 3'b011, rfull, 7'h03};
            end
        end else if (h[1:0] == 2'b10 && f3 == 3'd7) begin
            req = w64 ? "R6" : "R8";
            if (w64) begin
                off = int'(h[12:10]) * 8 + int'(h[9:7]) * 64;
                i12 = 12'(off); il = 1'b0;
                w = {i12[11:5], h[6:2], 5'd2, 3'b011, i12[4:0], 7'h23};
            end
        end
    endtask

    task automatic apply(input logic [15:0] h, input logic w64);
        @(posedge clk);
        hw_in = h;
        xlen64_in = w64;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check and still summarises.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] ew;
        logic        eil;
        string       rq;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R9: all-zero halfword is illegal with a zero word, in both modes.
        apply(16'h0000, 1'b0); check("R9", 32'h0, 1'b1);
        apply(16'h0000, 1'b1); check("R9", 32'h0, 1'b1);
        // R1: jump-and-link to x1 with offset -2.
        apply(16'h3FFD, 1'b0); check("R1", 32'hFFFFF0EF, 1'b0);
        // R2: add-immediate-word x31, x31, -1.
        apply(16'h3FFD, 1'b1); check("R2", 32'hFFFF8F9B, 1'b0);
        // R3: add-immediate-word slot with rd = x0 is illegal.
        apply(16'h2001, 1'b1); check("R3", 32'h0, 1'b1);
        // R4: load x9, 248(x8); R8: same halfword illegal at 32 bits.
        apply(16'h7C64, 1'b1); check("R4", 32'h0F843483, 1'b0);
        apply(16'h7C64, 1'b0); check("R8", 32'h0, 1'b1);

        // Exhaustive sweep over both width modes (R1..R9).
        for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < 65536; v++) begin
                apply(16'(v), 1'(m));
                model(16'(v), 1'(m), ew, eil, rq);
                check(rq, ew, eil);
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule